// File: doc/BRIEF.md
# CPU Status Flag Register Unit

This block holds the 8-bit status word of a small 8-bit CPU core. When the update strobe is high it computes carry, half-carry and signed overflow from the ALU operands and the operation class. It takes the carry of a shift or rotate from the shifter. It also obeys three explicit commands: a direct write of the whole word, a clear of the overflow flag, and a load of bit 6 of a tested memory byte into overflow. The parity flag is not stored. It is formed continuously from the accumulator.

The two bank-select bits of the word give the base address of the active eight-register bank in internal RAM. The block adds a register index to that base to give the RAM address of that register. Instruction decode, the ALU datapath and the RAM are outside this block.

Subtraction uses the not-borrow convention. The block forms `opa + ~opb + cin`, where `cin` is the incoming not-borrow.

Top module: `psw_unit`

## Requirements
- R1: After synchronous reset every stored flag is 0, so `psw` reads 00h when the accumulator is 00h.
- R2: Bit layout of `psw`, MSB first: carry (7), half-carry (6), user flag (5), bank select high (4), bank select low (3), overflow (2), constant 0 (1), parity (0). A write (`wr_en`) loads bits 7..2 from `wr_data` on the next edge. Bit 1 always reads 0, and bit 0 is not taken from `wr_data`.
- R3: Add (`op`=1) with `upd`: carry becomes the carry out of `opa+opb+cin`, and half-carry becomes the carry out of bit 3.
- R4: Subtract (`op`=2) with `upd`: carry becomes the not-borrow of `opa-opb-(1-cin)`, and half-carry becomes 1 when no borrow comes from bit 4.
- R5: For add and subtract, overflow becomes 1 exactly when the signed result leaves -128..+127.
- R6: Shift/rotate (`op`=3) with `upd`: carry takes `shift_cy`. Half-carry and overflow keep their values.
- R7: Logical class (`op`=0) with `upd` leaves carry, half-carry and overflow unchanged.
- R8: `clr_ov` clears overflow on the next edge. No input sets overflow except `bit_load`, an add or subtract, or a write.
- R9: `bit_load` copies `mem_byte[6]` into overflow.
- R10: `psw[0]` follows `acc` in the same cycle, so that the number of ones in `acc` plus `psw[0]` is even.
- R11: `bank_base` = {bank select high, bank select low} × 8, giving 00h, 08h, 10h or 18h. `reg_addr` = `bank_base` + `reg_sel`.
- R12: Priority: `wr_en` overrides every other input. `bit_load` beats `clr_ov`, and both beat the overflow value of a same-cycle update, while carry and half-carry still come from that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc | input | 8 | Current accumulator value |
| opa | input | 8 | First ALU operand |
| opb | input | 8 | Second ALU operand |
| cin | input | 1 | Carry in (not-borrow for subtract) |
| op | input | 2 | Operation class: 0 logic, 1 add, 2 subtract, 3 shift/rotate |
| shift_cy | input | 1 | Bit shifted out by the shifter |
| upd | input | 1 | Apply flag results of this ALU operation |
| clr_ov | input | 1 | Clear overflow |
| bit_load | input | 1 | Load overflow from mem_byte[6] |
| mem_byte | input | 8 | Tested memory byte |
| wr_en | input | 1 | Direct write of the status word |
| wr_data | input | 8 | Data for the direct write |
| reg_sel | input | 3 | Register index within the bank |
| psw | output | 8 | Status word |
| bank_base | output | 8 | RAM base address of the active bank |
| reg_addr | output | 8 | RAM address of the selected register |

## Verification
The bench builds the block with its default parameters: eight registers per bank and an 8-bit RAM address. With these values all four bank bases, from 00h up to the last register at 1Fh, can be reached through writes. With 8-bit operands, exhaustive-style random stimulus can hit every carry, half-carry and overflow boundary, including 7Fh+01h and 80h−01h. Random cycles mix updates with collisions of all three commands, so every priority pairing is exercised against the behavioural model.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int DW = 8;

  typedef enum logic [1:0] {
    OP_LOGIC = 2'd0,
    OP_ADD   = 2'd1,
    OP_SUB   = 2'd2,
    OP_SHIFT = 2'd3
  } alu_class_e;

  // stored part of the status word, bits 7..2
  typedef struct packed {
    logic       cy;
    logic       ac;
    logic       f0;
    logic [1:0] rs;
    logic       ov;
  } flags_t;
endpackage

// File: rtl/psw_arith.sv
module psw_arith
  import psw_pkg::*;
(
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic          cin,
  input  logic          is_sub,
  output logic          cy,
  output logic          ac,
  output logic          ov
);
  localparam int NIB = 4;

  logic [DW-1:0]  b_eff;
  logic           c_top;
  logic [DW-2:0]  unused_low;
  logic [DW-1:0]  unused_full;
  logic [NIB-1:0] unused_nib;

  // subtract is add of the complement with not-borrow carry-in
  assign b_eff = is_sub ? ~opb : opb;

  assign {ac, unused_nib} = {1'b0, opa[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]}
                            + {{NIB{1'b0}}, cin};
  assign {c_top, unused_low} = {1'b0, opa[DW-2:0]} + {1'b0, b_eff[DW-2:0]}
                               + {{(DW-1){1'b0}}, cin};
  assign {cy, unused_full} = {1'b0, opa} + {1'b0, b_eff} + {{DW{1'b0}}, cin};

  // signed overflow: carry into the sign bit differs from carry out of it
  assign ov = c_top ^ cy;
endmodule

// File: rtl/psw_parity.sv
module psw_parity
  import psw_pkg::*;
(
  input  logic [DW-1:0] acc,
  output logic          par
);
  // even overall count of ones including the flag
  assign par = ^acc;
endmodule

// File: rtl/psw_bank_map.sv
module psw_bank_map #(
  parameter int REGS_PER_BANK = 8,
  parameter int ADDR_W        = 8
) (
  input  logic [1:0]                       rs,
  input  logic [$clog2(REGS_PER_BANK)-1:0] reg_sel,
  output logic [ADDR_W-1:0]                bank_base,
  output logic [ADDR_W-1:0]                reg_addr
);
  localparam int RSEL_W = $clog2(REGS_PER_BANK);

  assign bank_base = ADDR_W'({rs, {RSEL_W{1'b0}}});
  assign reg_addr  = bank_base + ADDR_W'(reg_sel);
endmodule

// File: rtl/psw_unit.sv
module psw_unit
  import psw_pkg::*;
#(
  parameter int REGS_PER_BANK = 8,
  parameter int ADDR_W        = 8,
  localparam int RSEL_W       = $clog2(REGS_PER_BANK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        acc,
  input  logic [7:0]        opa,
  input  logic [7:0]        opb,
  input  logic              cin,
  input  logic [1:0]        op,
  input  logic              shift_cy,
  input  logic              upd,
  input  logic              clr_ov,
  input  logic              bit_load,
  input  logic [7:0]        mem_byte,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic [RSEL_W-1:0] reg_sel,
  output logic [7:0]        psw,
  output logic [ADDR_W-1:0] bank_base,
  output logic [ADDR_W-1:0] reg_addr
);
  flags_t     flags_q, flags_d;
  alu_class_e cls;
  logic       a_cy, a_ac, a_ov, par;
  logic       unused_in;

  assign cls       = alu_class_e'(op);
  assign unused_in = ^{wr_data[1:0], mem_byte[7], mem_byte[5:0]};

  psw_arith u_arith (
    .opa    (opa),
    .opb    (opb),
    .cin    (cin),
    .is_sub (cls == OP_SUB),
    .cy     (a_cy),
    .ac     (a_ac),
    .ov     (a_ov)
  );

  psw_parity u_par (
    .acc (acc),
    .par (par)
  );

  always_comb begin
    flags_d = flags_q;
    if (upd) begin
      case (cls)
        OP_ADD, OP_SUB: begin
          flags_d.cy = a_cy;
          flags_d.ac = a_ac;
          flags_d.ov = a_ov;
        end
        OP_SHIFT: flags_d.cy = shift_cy;
        default: ;
      endcase
    end
    if (bit_load)    flags_d.ov = mem_byte[6];
    else if (clr_ov) flags_d.ov = 1'b0;
    if (wr_en)       flags_d = flags_t'(wr_data[7:2]);
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_d;
  end

  assign psw = {flags_q, 1'b0, par};

  psw_bank_map #(
    .REGS_PER_BANK (REGS_PER_BANK),
    .ADDR_W        (ADDR_W)
  ) u_bank (
    .rs        (flags_q.rs),
    .reg_sel   (reg_sel),
    .bank_base (bank_base),
    .reg_addr  (reg_addr)
  );

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> psw[7:2] == $past(wr_data[7:2])); // R2
  AST_SHIFT_CARRY: assert property (@(posedge clk) disable iff (rst)
    (upd && cls == OP_SHIFT && !wr_en) |=> psw[7] == $past(shift_cy)); // R6
  AST_LOGIC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (upd && cls == OP_LOGIC && !wr_en && !bit_load && !clr_ov) |=> $stable(psw[7:2])); // R7
  AST_OV_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_ov && !bit_load && !wr_en) |=> !psw[2]); // R8
  AST_BIT_LOAD: assert property (@(posedge clk) disable iff (rst)
    (bit_load && !wr_en) |=> psw[2] == $past(mem_byte[6])); // R9
  AST_PARITY_EVEN: assert property (@(posedge clk) disable iff (rst)
    ($countones({acc, psw[0]}) % 2) == 0); // R10
  AST_BANK_BASE: assert property (@(posedge clk) disable iff (rst)
    bank_base == ADDR_W'(psw[4:3]) * ADDR_W'(REGS_PER_BANK)); // R11
endmodule

// File: tb/tb_psw_unit.sv
module tb_psw_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] acc = '0, opa = '0, opb = '0, mem_byte = '0, wr_data = '0;
  logic       cin = 0, shift_cy = 0, upd = 0, clr_ov = 0, bit_load = 0, wr_en = 0;
  logic [1:0] op = '0;
  logic [2:0] reg_sel = '0;
  logic [7:0] psw, bank_base, reg_addr;

  int total = 0, passed = 0;
  logic m_cy = 0, m_ac = 0, m_f0 = 0, m_ov = 0;
  logic [1:0] m_rs = '0;

  always #2 clk = ~clk;

  psw_unit dut (
    .clk(clk), .rst(rst), .acc(acc), .opa(opa), .opb(opb), .cin(cin), .op(op),
    .shift_cy(shift_cy), .upd(upd), .clr_ov(clr_ov), .bit_load(bit_load),
    .mem_byte(mem_byte), .wr_en(wr_en), .wr_data(wr_data), .reg_sel(reg_sel),
    .psw(psw), .bank_base(bank_base), .reg_addr(reg_addr)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act == exp) passed++;
    else $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
  endtask

  task automatic model_edge();
    int a, b, s, h, sa, sb, sr;
    if (rst) begin
      {m_cy, m_ac, m_f0, m_rs, m_ov} = '0;
    end else if (wr_en) begin
      {m_cy, m_ac, m_f0, m_rs, m_ov} = wr_data[7:2];
    end else begin
      if (upd && (op == 2'd1 || op == 2'd2)) begin
        a  = opa;
        b  = (op == 2'd2) ? 255 - opb : opb;
        s  = a + b + cin;
        h  = (a % 16) + (b % 16) + cin;
        sa = (a > 127) ? a - 256 : a;
        sb = (b > 127) ? b - 256 : b;
        sr = sa + sb + cin;
        m_cy = (s > 255);
        m_ac = (h > 15);
        m_ov = (sr > 127) || (sr < -128);
      end else if (upd && op == 2'd3) begin
        m_cy = shift_cy;
      end
      if (bit_load)    m_ov = mem_byte[6];
      else if (clr_ov) m_ov = 1'b0;
    end
  endtask

  task automatic compare_all();
    int ones;
    ones = $countones(acc);
    chk("R3 R4 R6 R7 carry", psw[7], m_cy);
    chk("R3 R4 R6 R7 half-carry", psw[6], m_ac);
    chk("R2 user/bank bits", psw[5:3], {m_f0, m_rs});
    chk("R5 R8 R9 R12 overflow", psw[2], m_ov);
    chk("R2 bit1 zero", psw[1], 0);
    chk("R10 parity", psw[0], ones % 2);
    chk("R11 bank base", bank_base, m_rs * 8);
    chk("R11 register address", reg_addr, m_rs * 8 + reg_sel);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    if (!rst) compare_all();
    {upd, clr_ov, bit_load, wr_en} = '0;
  endtask

  task automatic arith(logic [1:0] o, logic [7:0] a, logic [7:0] b, logic c);
    op = o; opa = a; opb = b; cin = c; upd = 1'b1;
    step();
  endtask

  task automatic write(logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
  endtask

  initial begin
    #800000;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    step(); step();
    chk("R1 reset word", psw, 8'h00);
    rst = 1'b0;
    step();
    chk("R1 after release", psw, 8'h00);

    write(8'hFF);
    chk("R2 write FF reads FC", psw, 8'hFC);
    reg_sel = 3'd5; #1;
    chk("R11 bank 3 base", bank_base, 8'h18);
    chk("R11 bank 3 R5", reg_addr, 8'h1D);
    write(8'h08);
    chk("R11 bank 1 base", bank_base, 8'h08);

    write(8'h00);
    arith(2'd1, 8'h0F, 8'h01, 1'b0);
    chk("R3 add 0F+01 carry/half", psw[7:6], 2'b01);
    arith(2'd1, 8'hF0, 8'h10, 1'b0);
    chk("R3 add F0+10 carry", psw[7], 1);
    arith(2'd1, 8'h7F, 8'h01, 1'b0);
    chk("R5 add 7F+01 overflow", psw[2], 1);
    arith(2'd2, 8'h00, 8'h01, 1'b1);
    chk("R4 sub 00-01 borrow", psw[7:6], 2'b00);
    arith(2'd2, 8'h80, 8'h01, 1'b1);
    chk("R5 sub 80-01 overflow", psw[2], 1);
    chk("R4 sub 80-01 not-borrow", psw[7], 1);
    arith(2'd2, 8'h10, 8'h01, 1'b1);
    chk("R4 sub 10-01 nibble borrow", psw[6], 0);

    arith(2'd1, 8'h7F, 8'h01, 1'b0);
    shift_cy = 1'b0;
    arith(2'd3, 8'h00, 8'h00, 1'b0);
    chk("R6 shift carry and kept flags", psw[7:6], 2'b01);
    chk("R6 shift keeps overflow", psw[2], 1);
    arith(2'd0, 8'hFF, 8'hFF, 1'b1);
    chk("R7 logic op holds flags", psw[7:2], 6'b010001);

    clr_ov = 1'b1; step();
    chk("R8 clear overflow", psw[2], 0);
    mem_byte = 8'h40; bit_load = 1'b1; step();
    chk("R9 bit6 high", psw[2], 1);
    mem_byte = 8'hBF; bit_load = 1'b1; step();
    chk("R9 bit6 low", psw[2], 0);

    clr_ov = 1'b1; op = 2'd1; opa = 8'h7F; opb = 8'h01; cin = 0; upd = 1'b1; step();
    chk("R12 clear beats update overflow", psw[7:2], 6'b010000);
    mem_byte = 8'h40; bit_load = 1'b1; clr_ov = 1'b1; step();
    chk("R12 bit load beats clear", psw[2], 1);
    wr_en = 1'b1; wr_data = 8'h24; bit_load = 1'b1; mem_byte = 8'h00;
    upd = 1'b1; op = 2'd1; opa = 8'hFF; opb = 8'hFF; step();
    chk("R12 write beats all", psw[7:2], 6'b001001);

    acc = 8'h07; #1;
    chk("R10 odd ones", psw[0], 1);
    acc = 8'h03; #1;
    chk("R10 even ones", psw[0], 0);

    for (int i = 0; i < 4000; i++) begin
      acc = 8'($urandom); opa = 8'($urandom); opb = 8'($urandom);
      cin = 1'($urandom); op = 2'($urandom); shift_cy = 1'($urandom);
      mem_byte = 8'($urandom); wr_data = 8'($urandom); reg_sel = 3'($urandom);
      upd = ($urandom % 4) != 0;
      clr_ov = ($urandom % 6) == 0;
      bit_load = ($urandom % 6) == 0;
      wr_en = ($urandom % 10) == 0;
      if (i % 500 == 0) rst = 1'b1;
      step();
      rst = 1'b0;
    end

    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule